// File: doc/BRIEF.md
# Quadword Drain DMA with Stall Publication

This block is a device-to-memory DMA channel that empties a 128-bit output FIFO into memory in normal (non-chained) mode. On every clock cycle in which it is running it issues one burst descriptor. The burst length is the smaller of the quadwords still owed and the quadwords waiting in the FIFO. The memory address advances by 16 bytes for each quadword, and the remaining count drops by the same amount. The same descriptor tells the FIFO how many entries to pop and tells the memory side where to write them.

When the count reaches zero, the channel may be acting as the stall-control source. This is the case when a global selector names its channel number. It then records its final memory address in a stall-address register and raises one of three per-destination stall flags, which a downstream channel uses to throttle itself. After a programmable delay proportional to the size of the last burst, the completion service runs. It drops the stall flags, clears the start bit and raises the channel interrupt.

Software programs the channel through a small register file: memory address, count, control and stall configuration, plus two read-only views of the stall state. A count written with nonzero bits above its 16-bit field is rejected when the channel is started.

Top module: `qw_drain_dma`

## Requirements
- R1: While running, each cycle with `fifo_level` > 0 presents `xfer_valid`=1 with `xfer_qwc` = min(remaining count, `fifo_level`) and `xfer_addr` = current address. At that edge the address grows by 16×`xfer_qwc` and the count shrinks by `xfer_qwc`.
- R2: `xfer_valid` stays 0 while the start bit (control register 2, bit 0) is clear, while the interrupt is pending, or while the count is zero.
- R3: On the final step, if the selector (register 3, bits [1:0]) equals the channel number `CH_ID` (default 1), the stall address (register 4, port `stall_addr`) is loaded with the final address. Otherwise it keeps its value.
- R4: Under the same condition, the destination field (register 3, bits [3:2]) sets stall flag bit dest−1 for values 1..3 and sets no flag for 0. Flags appear on `stall_flags` and in register 5, and at most one is set.
- R5: The completion service takes place D+1 clock edges after the final step, where D = last burst length × register 3 bits [15:8]. It clears all stall flags and the start bit, and sets `irq`.
- R6: Writing the start bit while count bits [31:16] are nonzero clears the whole count and the start bit, and raises `irq` with no transfer.
- R7: Control bits [4:2] (mode and tag-transfer requests) are ignored: they read back as 0 and the transfer runs as a normal one.
- R8: Writing 1 to control bit 1 clears a pending `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write index |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read index |
| rd_data | output | 32 | Register read data (combinational) |
| fifo_level | input | 4 | Quadwords available in the output FIFO |
| xfer_valid | output | 1 | Burst issued this cycle |
| xfer_addr | output | 32 | Memory byte address of the burst |
| xfer_qwc | output | 4 | Burst length in quadwords (also FIFO pop count) |
| stall_flags | output | 3 | Per-destination stall flags |
| stall_addr | output | 32 | Published stall address |
| irq | output | 1 | Channel interrupt pending |

## Verification
The bench varies the FIFO level on every cycle. This exposes a design that sizes bursts from the count alone or from the FIFO alone, since the issued length or the address stride would then drift from the model. Stall publication is run with matching and non-matching selectors and with every destination value. A design that ignores the selector, or decodes the destination off by one, sets the wrong flag or overwrites the stall address. The completion delay is measured in cycles against last-burst × per-quadword delay, including a zero delay. Separate directed cases cover an oversized count at start, a start issued while the interrupt is still pending, and a start with a zero count. A design that got any of these wrong would issue bursts it must not, or would fail to raise the interrupt.

// File: rtl/qwd_pkg.sv
package qwd_pkg;
   localparam int RA_W = 3;
   typedef enum logic [RA_W-1:0] {
      RA_MADDR  = 3'd0,
      RA_COUNT  = 3'd1,
      RA_CTRL   = 3'd2,
      RA_STCFG  = 3'd3,
      RA_STADDR = 3'd4,
      RA_STFLAG = 3'd5
   } reg_addr_e;
   localparam int CB_START = 0;
   localparam int CB_IRQ   = 1;
   localparam int SEL_W    = 2;
endpackage

// File: rtl/qwd_step.sv
module qwd_step #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16,
   parameter int LVL_W  = 4
) (
   input  logic              run,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [LVL_W-1:0]  level,
   input  logic [ADDR_W-1:0] addr,
   output logic              valid,
   output logic [LVL_W-1:0]  qwc,
   output logic [ADDR_W-1:0] next_addr,
   output logic [CNT_W-1:0]  next_cnt,
   output logic              last
);
   logic [CNT_W-1:0] lvl_ext;
   logic [CNT_W-1:0] take;

   always_comb begin
      lvl_ext   = CNT_W'(level);
      take      = (cnt < lvl_ext) ? cnt : lvl_ext;
      valid     = run && (take != '0);
      qwc       = LVL_W'(take);
      next_addr = addr + (ADDR_W'(take) << 4);
      next_cnt  = cnt - take;
      last      = valid && (next_cnt == '0);
   end
endmodule

// File: rtl/qwd_timer.sv
module qwd_timer #(
   parameter int LVL_W = 4,
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LVL_W-1:0] qwc,
   input  logic [DLY_W-1:0] per_qw,
   output logic             busy,
   output logic             fire
);
   localparam int TMR_W = LVL_W + DLY_W;
   logic [TMR_W-1:0] remain;

   assign fire = busy && (remain == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         remain <= '0;
      end else if (load) begin
         busy   <= 1'b1;
         remain <= TMR_W'(qwc) * TMR_W'(per_qw);
      end else if (busy) begin
         if (remain == '0) busy <= 1'b0;
         else              remain <= remain - 1'b1;
      end
   end

   a_r5_fire_single: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);
endmodule

// File: rtl/qwd_stall.sv
module qwd_stall #(
   parameter int ADDR_W = 32,
   parameter int N_DEST = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              record,
   input  logic [1:0]        dest,
   input  logic [ADDR_W-1:0] fin_addr,
   input  logic              clear,
   output logic [N_DEST-1:0] flags,
   output logic [ADDR_W-1:0] st_addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st_addr <= '0;
      else if (record) st_addr <= fin_addr;
   end

   for (genvar g = 0; g < N_DEST; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flags[g] <= 1'b0;
         else if (clear)  flags[g] <= 1'b0;
         else if (record && (dest == 2'(g + 1))) flags[g] <= 1'b1;
      end
   end

   a_r4_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(flags));
endmodule

// File: rtl/qw_drain_dma.sv
module qw_drain_dma #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16,
   parameter int REG_W  = 32,
   parameter int LVL_W  = 4,
   parameter int DLY_W  = 8,
   parameter int N_DEST = 3,
   parameter int CH_ID  = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [qwd_pkg::RA_W-1:0] wr_addr,
   input  logic [REG_W-1:0]         wr_data,
   input  logic [qwd_pkg::RA_W-1:0] rd_addr,
   output logic [REG_W-1:0]         rd_data,
   input  logic [LVL_W-1:0]         fifo_level,
   output logic                     xfer_valid,
   output logic [ADDR_W-1:0]        xfer_addr,
   output logic [LVL_W-1:0]         xfer_qwc,
   output logic [N_DEST-1:0]        stall_flags,
   output logic [ADDR_W-1:0]        stall_addr,
   output logic                     irq
);
   import qwd_pkg::*;

   localparam int HI_W = REG_W - CNT_W;

   if (ADDR_W > REG_W || CNT_W >= REG_W || LVL_W > CNT_W) begin : g_bad_width
      $error("qw_drain_dma: width parameters inconsistent");
   end
   if (DLY_W > 8 || N_DEST > 3 || N_DEST < 1) begin : g_bad_cfg
      $error("qw_drain_dma: delay or destination parameters out of range");
   end

   logic [ADDR_W-1:0] maddr;
   logic [CNT_W-1:0]  cnt;
   logic [HI_W-1:0]   cnt_hi;
   logic              start;
   logic              irq_q;
   logic [SEL_W-1:0]  sel;
   logic [1:0]        dest;
   logic [DLY_W-1:0]  per_qw;

   logic              run, busy, fire, last;
   logic [ADDR_W-1:0] next_addr;
   logic [CNT_W-1:0]  next_cnt;

   assign run = start && !irq_q && !busy;

   qwd_step #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_step (
      .run(run), .cnt(cnt), .level(fifo_level), .addr(maddr),
      .valid(xfer_valid), .qwc(xfer_qwc), .next_addr(next_addr),
      .next_cnt(next_cnt), .last(last));

   qwd_timer #(.LVL_W(LVL_W), .DLY_W(DLY_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(last), .qwc(xfer_qwc),
      .per_qw(per_qw), .busy(busy), .fire(fire));

   qwd_stall #(.ADDR_W(ADDR_W), .N_DEST(N_DEST)) u_stall (
      .clk(clk), .rst_n(rst_n),
      .record(last && (sel == SEL_W'(CH_ID))), .dest(dest),
      .fin_addr(next_addr), .clear(fire),
      .flags(stall_flags), .st_addr(stall_addr));

   assign xfer_addr = maddr;
   assign irq       = irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         maddr  <= '0;
         cnt    <= '0;
         cnt_hi <= '0;
         start  <= 1'b0;
         irq_q  <= 1'b0;
         sel    <= '0;
         dest   <= '0;
         per_qw <= '0;
      end else begin
         if (wr_en) begin
            case (wr_addr)
               RA_MADDR: maddr <= wr_data[ADDR_W-1:0];
               RA_COUNT: {cnt_hi, cnt} <= wr_data;
               RA_CTRL: begin
                  if (wr_data[CB_IRQ]) irq_q <= 1'b0;
                  start <= wr_data[CB_START];
                  if (wr_data[CB_START] && (cnt_hi != '0)) begin
                     cnt    <= '0;
                     cnt_hi <= '0;
                     start  <= 1'b0;
                     irq_q  <= 1'b1;
                  end
               end
               RA_STCFG: begin
                  sel    <= wr_data[SEL_W-1:0];
                  dest   <= wr_data[3:2];
                  per_qw <= wr_data[8 +: DLY_W];
               end
               default: ;
            endcase
         end
         if (xfer_valid) begin
            maddr <= next_addr;
            cnt   <= next_cnt;
         end
         if (fire) begin
            start <= 1'b0;
            irq_q <= 1'b1;
         end
      end
   end

   always_comb begin
      case (rd_addr)
         RA_MADDR:  rd_data = REG_W'(maddr);
         RA_COUNT:  rd_data = REG_W'({cnt_hi, cnt});
         RA_CTRL:   rd_data = REG_W'({irq_q, start});
         RA_STCFG:  rd_data = REG_W'({per_qw, 4'b0000, dest, sel});
         RA_STADDR: rd_data = REG_W'(stall_addr);
         RA_STFLAG: rd_data = REG_W'(stall_flags);
         default:   rd_data = '0;
      endcase
   end

   a_r2_quiet_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
      (!start || irq_q) |-> !xfer_valid);
   a_r1_burst_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |-> (xfer_qwc != '0) && (xfer_qwc <= fifo_level)
                     && (CNT_W'(xfer_qwc) <= cnt));
   a_r1_addr_stride: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |=> maddr == $past(maddr) + (ADDR_W'($past(xfer_qwc)) << 4));
   a_r5_irq_stops_channel: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> !start && (stall_flags == '0));
endmodule

// File: tb/tb_qw_drain_dma.sv
`timescale 1ns/1ps
module tb_qw_drain_dma;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [2:0]  wr_addr;
   logic [31:0] wr_data;
   logic [2:0]  rd_addr;
   logic [31:0] rd_data;
   logic [3:0]  fifo_level;
   logic        xfer_valid;
   logic [31:0] xfer_addr;
   logic [3:0]  xfer_qwc;
   logic [2:0]  stall_flags;
   logic [31:0] stall_addr;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] exp_staddr = 32'h0;

   always #4 clk = ~clk;

   qw_drain_dma dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .fifo_level(fifo_level), .xfer_valid(xfer_valid), .xfer_addr(xfer_addr),
      .xfer_qwc(xfer_qwc), .stall_flags(stall_flags), .stall_addr(stall_addr),
      .irq(irq));

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rdreg(input logic [2:0] a, output logic [31:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   function automatic logic [2:0] exp_flag(input int sel, input int dest);
      if (sel == 1 && dest != 0) return 3'(1 << (dest - 1));
      return 3'b000;
   endfunction

   task automatic run_xfer(input logic [31:0] a, input int c, input int dly,
                           input int sel, input int dest, input logic [31:0] extra);
      logic [31:0] v;
      int ma, mc, n, lastn, k, guard;
      bit done;
      fifo_level = 4'd0;
      wr(3'd3, 32'((dly << 8) | (dest << 2) | sel));
      wr(3'd0, a);
      wr(3'd1, 32'(c));
      wr(3'd2, 32'h1 | extra);
      if (extra != 0) begin
         rdreg(3'd2, v);
         chk(v[4:0] == 5'b00001, "R7 ctrl readback", v, 32'h1);
      end
      ma = int'(a); mc = c; done = 0; guard = 0; lastn = 0;
      while (!done && guard < 2000) begin
         fifo_level = 4'($urandom % 16);
         #1;
         n = (mc < int'(fifo_level)) ? mc : int'(fifo_level);
         chk(xfer_valid == (n != 0), "R1 valid", 32'(xfer_valid), 32'(n != 0));
         if (n != 0) begin
            chk(xfer_qwc == 4'(n), "R1 qwc", 32'(xfer_qwc), 32'(n));
            chk(xfer_addr == 32'(ma), "R1 addr", xfer_addr, 32'(ma));
            ma = ma + 16 * n;
            mc = mc - n;
            if (mc == 0) begin done = 1; lastn = n; end
         end
         guard++;
         @(negedge clk);
      end
      fifo_level = 4'd0;
      if (sel == 1) exp_staddr = 32'(ma);
      #1;
      chk(stall_flags == exp_flag(sel, dest), "R4 flags", 32'(stall_flags),
          32'(exp_flag(sel, dest)));
      chk(stall_addr == exp_staddr, "R3 stall addr", stall_addr, exp_staddr);
      k = 1;
      while (!irq && k < 100) begin
         @(negedge clk);
         k++;
      end
      chk(k == lastn * dly + 2, "R5 delay", 32'(k), 32'(lastn * dly + 2));
      chk(stall_flags == 3'b000, "R5 flags cleared", 32'(stall_flags), 32'h0);
      rdreg(3'd2, v);
      chk(v[1:0] == 2'b10, "R5 start cleared irq set", v, 32'h2);
      wr(3'd2, 32'h2);
      #1;
      chk(irq == 1'b0, "R8 irq clear", 32'(irq), 32'h0);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd4242));
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      rd_addr = '0; fifo_level = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(irq == 1'b0, "reset irq", 32'(irq), 32'h0);
      chk(xfer_valid == 1'b0, "reset xfer", 32'(xfer_valid), 32'h0);
      chk(stall_flags == 3'b000, "reset flags", 32'(stall_flags), 32'h0);
      rdreg(3'd2, v);
      chk(v == 32'h0, "reset ctrl", v, 32'h0);

      run_xfer(32'h0000_1000, 5, 2, 1, 1, 32'h0);
      run_xfer(32'h0000_2000, 40, 0, 2, 3, 32'h0);
      run_xfer(32'h0000_3000, 1, 3, 1, 3, 32'h1C);
      for (int i = 0; i < 12; i++)
         run_xfer($urandom & 32'hFFFF_FFF0, 1 + int'($urandom % 60),
                  int'($urandom % 4), int'($urandom % 4), int'($urandom % 4), 32'h0);

      // R6 oversized count
      wr(3'd1, 32'h0002_0007);
      fifo_level = 4'd8;
      wr(3'd2, 32'h1);
      #1;
      chk(irq == 1'b1, "R6 irq", 32'(irq), 32'h1);
      chk(xfer_valid == 1'b0, "R6 no xfer", 32'(xfer_valid), 32'h0);
      rdreg(3'd2, v);
      chk(v[0] == 1'b0, "R6 start cleared", v, 32'h2);
      rdreg(3'd1, v);
      chk(v == 32'h0, "R6 count cleared", v, 32'h0);

      // R2 start while irq pending
      wr(3'd1, 32'd6);
      wr(3'd2, 32'h1);
      #1;
      chk(xfer_valid == 1'b0, "R2 irq pending blocks", 32'(xfer_valid), 32'h0);
      fifo_level = 4'd0;
      wr(3'd2, 32'h2);
      wr(3'd2, 32'h0);
      fifo_level = 4'd8;
      #1;
      chk(xfer_valid == 1'b0, "R2 start clear blocks", 32'(xfer_valid), 32'h0);
      rdreg(3'd1, v);
      chk(v == 32'd6, "R2 count untouched", v, 32'd6);

      // R2 zero count
      wr(3'd1, 32'd0);
      wr(3'd2, 32'h1);
      #1;
      chk(xfer_valid == 1'b0, "R2 zero count blocks", 32'(xfer_valid), 32'h0);
      chk(irq == 1'b0, "R2 zero count no irq", 32'(irq), 32'h0);
      wr(3'd2, 32'h0);
      fifo_level = 4'd0;

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule